// File: doc/BRIEF.md
# Software-Refilled Page Translation Buffer

This block translates 24-bit virtual addresses, split into 4 KB pages, through eight fully associative entries. Each entry pairs a 12-bit virtual page tag with a 12-bit physical page and a 2-bit access mode. While the unit is switched on, in user mode and with the interrupt flag clear, every access is looked up. A hit needs a tag match and an access mode that permits the access type. A hit yields `{physical page, offset}`. Any other access records a fault word, raises a fault and drops the unit into kernel mode. In kernel mode, or whenever the unit is off, addresses pass through unchanged.

There is no hardware table walk. After a fault, software finds the mapping and returns it through the refill port. The refill writes the entry chosen by a rotating 3-bit head pointer and keeps the tag of the faulting access. An indexed port lets software read or overwrite any entry. Writing zero to an entry invalidates it. Turning the unit off and then on again empties the whole buffer.

Top module: `page_xlate_tlb`

## Requirements
- R1: After reset the unit is off, in kernel mode, with the interrupt flag at 0, the fault word at 0, the head pointer at 0 and all eight entries reading as zero.
- R2: When the unit is off, the user bit is 0, or the interrupt flag is 1, `phys_addr` equals `req_vaddr` and `access_fault` stays 0.
- R3: While translating, a hit drives `phys_addr` to `{entry physical page, req_vaddr[11:0]}` in the same cycle.
- R4: Access codes on `req_acc` and access modes in entries share one encoding: 0 = none, 1 = code, 2 = read-only, 3 = read-write. A fetch (1) hits only mode 1, a read (2) hits mode 2 or 3, a write (3) hits only mode 3, and code 0 never hits.
- R5: When several entries hit the same access, the one with the lowest index supplies the translation.
- R6: A request on `int_we` to change the interrupt flag is refused while translating and accepted otherwise.
- R7: A translating access (`req_acc` nonzero) that does not hit raises `access_fault` in the same cycle. On the next edge it latches the fault word, with `req_acc` zero-extended into bits 15:12 and `req_vaddr[23:12]` in bits 11:0, and clears the user bit.
- R8: A refill writes the entry at the head pointer with the tag from the fault word, `rf_ppn` and `rf_mode`, then advances the head pointer by one, wrapping modulo 8.
- R9: The indexed port reads and writes an entry as 26 bits: tag in [25:14], physical page in [13:2], mode in [1:0]. Writing zero makes that entry miss.
- R10: A control write that turns the unit on from off clears all entries and resets the head pointer to 0. An all-zero entry never hits, not even for tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Writes the enable and user bits |
| ctl_en | input | 1 | New enable bit |
| ctl_user | input | 1 | New user-mode bit |
| int_we | input | 1 | Request to change the interrupt flag |
| int_val | input | 1 | Requested interrupt flag value |
| req_acc | input | 2 | Access type (0 none, 1 fetch, 2 read, 3 write) |
| req_vaddr | input | 24 | Virtual address |
| rf_we | input | 1 | Refill strobe |
| rf_mode | input | 2 | Refill access mode |
| rf_ppn | input | 12 | Refill physical page |
| sw_we | input | 1 | Indexed entry write |
| sw_idx | input | 3 | Entry index for the indexed read and write |
| sw_data | input | 26 | Indexed write data |
| sw_rdata | output | 26 | Indexed read data |
| phys_addr | output | 24 | Physical address |
| access_fault | output | 1 | Fault on the current access |
| fault_word | output | 16 | Latched fault word |
| xlate_on | output | 1 | Translation and checking active |
| unit_en | output | 1 | Enable bit |
| user_mode | output | 1 | User-mode bit |
| int_flag | output | 1 | Interrupt flag |

## Verification
The assertions assume that a refill and an indexed write aimed at the same entry in the same cycle resolve in favour of the refill. They also assume that software only refills after a fault has been latched, so that the fault word holds a meaningful tag. The stimulus never issues a refill and an indexed write together, and it refills only directly after a checked fault. After every fault the bench restores user mode with a control write that keeps the enable bit high. This way the buffer is never cleared by accident between lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TAG_W  = 12;
  localparam int PPN_W  = 12;
  localparam int OFF_W  = 12;
  localparam int MODE_W = 2;
  localparam int VA_W   = TAG_W + OFF_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int ENT_W  = TAG_W + PPN_W + MODE_W;
  localparam int FW_W   = 16;

  typedef enum logic [MODE_W-1:0] {
    ACC_NONE = 2'd0,
    ACC_CODE = 2'd1,
    ACC_RO   = 2'd2,
    ACC_RW   = 2'd3
  } acc_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    acc_e             mode;
  } tlb_ent_t;

  // stored mode versus requested access
  function automatic logic rights_ok(acc_e have, acc_e want);
    case (want)
      ACC_CODE: rights_ok = (have == ACC_CODE);
      ACC_RO:   rights_ok = (have == ACC_RO) || (have == ACC_RW);
      ACC_RW:   rights_ok = (have == ACC_RW);
      default:  rights_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] join_addr(logic [PPN_W-1:0] ppn,
                                                logic [OFF_W-1:0] off);
    join_addr = {ppn, off};
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [TAG_W-1:0] look_tag,
  input  acc_e             look_acc,
  input  logic             rf_we,
  input  logic [IDX_W-1:0] rf_idx,
  input  tlb_ent_t         rf_ent,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  tlb_ent_t         sw_ent,
  output tlb_ent_t         rd_ent,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  tlb_ent_t ent_q [NUM_ENT];
  logic [NUM_ENT-1:0] match_v;
  logic [NUM_ENT-1:0] live_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (rf_we && rf_idx == IDX_W'(i))      ent_q[i] <= rf_ent;
        else if (sw_we && sw_idx == IDX_W'(i)) ent_q[i] <= sw_ent;
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign match_v[g] = (ent_q[g].tag == look_tag) &&
                        rights_ok(ent_q[g].mode, look_acc);
    assign live_v[g]  = (ent_q[g].mode != ACC_NONE);
  end

  // lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    hit_ppn = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match_v[i] && !found) begin
        found   = 1'b1;
        hit_ppn = ent_q[i].ppn;
      end
    end
    hit = found;
  end

  assign rd_ent = ent_q[sw_idx];

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($countones(live_v) == 0));

  // R8
  refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !clr) |=> (ent_q[$past(rf_idx)] == $past(rf_ent)));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_en,
  input  logic             ctl_user,
  input  logic             int_we,
  input  logic             int_val,
  input  acc_e             look_acc,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             hit,
  input  logic             rf_we,
  output logic             xlate_on,
  output logic             fault_now,
  output logic             clr_all,
  output logic             en_q,
  output logic             user_q,
  output logic             int_q,
  output logic [FW_W-1:0]  fault_word,
  output logic [IDX_W-1:0] head_q
);
  assign xlate_on  = en_q && user_q && !int_q;
  assign fault_now = xlate_on && (look_acc != ACC_NONE) && !hit;
  assign clr_all   = ctl_we && ctl_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      user_q     <= 1'b0;
      int_q      <= 1'b0;
      fault_word <= '0;
      head_q     <= '0;
    end else begin
      if (ctl_we) en_q <= ctl_en;
      if (fault_now)   user_q <= 1'b0;
      else if (ctl_we) user_q <= ctl_user;
      if (int_we && !xlate_on) int_q <= int_val;
      if (fault_now)
        fault_word <= {{(FW_W-TAG_W-MODE_W){1'b0}}, look_acc, look_tag};
      if (clr_all)    head_q <= '0;
      else if (rf_we) head_q <= head_q + 1'b1;
    end
  end

  // R7
  fault_to_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> !user_q);

  // R6
  int_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_on |=> $stable(int_q));

  // R10
  head_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (head_q == '0));
endmodule

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_en,
  input  logic             ctl_user,
  input  logic             int_we,
  input  logic             int_val,
  input  logic [1:0]       req_acc,
  input  logic [23:0]      req_vaddr,
  input  logic             rf_we,
  input  logic [1:0]       rf_mode,
  input  logic [11:0]      rf_ppn,
  input  logic             sw_we,
  input  logic [2:0]       sw_idx,
  input  logic [25:0]      sw_data,
  output logic [25:0]      sw_rdata,
  output logic [23:0]      phys_addr,
  output logic             access_fault,
  output logic [15:0]      fault_word,
  output logic             xlate_on,
  output logic             unit_en,
  output logic             user_mode,
  output logic             int_flag
);
  acc_e             acc;
  logic [TAG_W-1:0] tag;
  logic [OFF_W-1:0] off;
  logic             hit, clr_all;
  logic [PPN_W-1:0] hit_ppn;
  logic [IDX_W-1:0] head;
  tlb_ent_t         rf_ent, sw_ent, rd_ent;

  assign acc    = acc_e'(req_acc);
  assign tag    = req_vaddr[VA_W-1:OFF_W];
  assign off    = req_vaddr[OFF_W-1:0];
  assign rf_ent = '{tag: fault_word[TAG_W-1:0], ppn: rf_ppn, mode: acc_e'(rf_mode)};
  assign sw_ent = tlb_ent_t'(sw_data);
  assign sw_rdata = rd_ent;

  tlb_ctrl #(.NUM_ENT(NUM_ENT)) u_ctrl (
    .clk, .rst_n, .ctl_we, .ctl_en, .ctl_user, .int_we, .int_val,
    .look_acc(acc), .look_tag(tag), .hit, .rf_we,
    .xlate_on, .fault_now(access_fault), .clr_all,
    .en_q(unit_en), .user_q(user_mode), .int_q(int_flag),
    .fault_word, .head_q(head)
  );

  tlb_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk, .rst_n, .clr(clr_all), .look_tag(tag), .look_acc(acc),
    .rf_we, .rf_idx(head), .rf_ent, .sw_we, .sw_idx(IDX_W'(sw_idx)),
    .sw_ent, .rd_ent, .hit, .hit_ppn
  );

  assign phys_addr = (xlate_on && hit) ? join_addr(hit_ppn, off) : req_vaddr;

  // R2
  fault_only_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_fault |-> xlate_on);
endmodule

// File: tb/page_xlate_tlb_tb.sv
module page_xlate_tlb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_en = 0, ctl_user = 0, int_we = 0, int_val = 0;
  logic [1:0] req_acc = 0;
  logic [23:0] req_vaddr = 0;
  logic rf_we = 0;
  logic [1:0] rf_mode = 0;
  logic [11:0] rf_ppn = 0;
  logic sw_we = 0;
  logic [2:0] sw_idx = 0;
  logic [25:0] sw_data = 0;
  logic [25:0] sw_rdata;
  logic [23:0] phys_addr;
  logic access_fault, xlate_on, unit_en, user_mode, int_flag;
  logic [15:0] fault_word;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  page_xlate_tlb u_dut (.*);

  typedef struct packed {
    logic [1:0]  acc;
    logic [23:0] va;
    logic        flt;
    logic [23:0] pa;
  } vec_t;

  // entries preloaded: 0:{010,A10,code} 1:{020,B20,ro} 2:{030,C30,rw} 3:{020,D20,rw}
  localparam vec_t VT [9] = '{
    '{2'd1, 24'h010123, 1'b0, 24'hA10123},  // R3 fetch on code page
    '{2'd2, 24'h010004, 1'b1, 24'h0},       // R4 read of code page
    '{2'd2, 24'h020FFF, 1'b0, 24'hB20FFF},  // R5 entry 1 beats entry 3
    '{2'd3, 24'h020800, 1'b0, 24'hD20800},  // R4 write skips ro entry 1
    '{2'd3, 24'h030000, 1'b0, 24'hC30000},  // R3
    '{2'd1, 24'h030456, 1'b1, 24'h0},       // R4 fetch of data page
    '{2'd2, 24'h030ABC, 1'b0, 24'hC30ABC},  // R4 read of rw page
    '{2'd3, 24'h040001, 1'b1, 24'h0},       // R7 miss
    '{2'd2, 24'h000000, 1'b1, 24'h0}        // R10 zero entries never hit
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(input logic en, input logic usr);
    ctl_we = 1; ctl_en = en; ctl_user = usr;
    tick();
    ctl_we = 0;
  endtask

  task automatic sw_write(input logic [2:0] i, input logic [25:0] d);
    sw_we = 1; sw_idx = i; sw_data = d;
    tick();
    sw_we = 0;
  endtask

  task automatic lookup(input logic [1:0] a, input logic [23:0] va,
                        input logic flt, input logic [23:0] pa, input string req);
    req_acc = a; req_vaddr = va;
    #1;
    chk(access_fault == flt, req, 32'(access_fault), 32'(flt));
    if (!flt) chk(phys_addr == pa, req, 32'(phys_addr), 32'(pa));
    @(posedge clk);
    #1 req_acc = 0;
    @(negedge clk);
    if (flt) begin
      chk(fault_word == {2'b00, a, va[23:12]}, "R7 word", 32'(fault_word),
          32'({2'b00, a, va[23:12]}));
      chk(user_mode == 1'b0, "R7 kernel", 32'(user_mode), 32'd0);
      ctl(1'b1, 1'b1);
    end
  endtask

  task automatic refill(input logic [1:0] m, input logic [11:0] p);
    rf_we = 1; rf_mode = m; rf_ppn = p;
    tick();
    rf_we = 0;
  endtask

  task automatic rd_chk(input logic [2:0] i, input logic [25:0] e, input string req);
    sw_idx = i;
    #1 chk(sw_rdata == e, req, 32'(sw_rdata), 32'(e));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(unit_en == 0 && user_mode == 0 && int_flag == 0, "R1 bits",
        32'({unit_en, user_mode, int_flag}), 32'd0);
    chk(fault_word == 0, "R1 fault word", 32'(fault_word), 32'd0);
    for (int i = 0; i < 8; i++) rd_chk(3'(i), 26'd0, "R1 entry");
    // R2 off: passthrough
    lookup(2'd2, 24'h040001, 1'b0, 24'h040001, "R2 off");
    ctl(1'b1, 1'b0);
    lookup(2'd3, 24'h123456, 1'b0, 24'h123456, "R2 kernel");
    // R9 preload and read back
    sw_write(3'd0, {12'h010, 12'hA10, 2'd1});
    sw_write(3'd1, {12'h020, 12'hB20, 2'd2});
    sw_write(3'd2, {12'h030, 12'hC30, 2'd3});
    sw_write(3'd3, {12'h020, 12'hD20, 2'd3});
    rd_chk(3'd2, {12'h030, 12'hC30, 2'd3}, "R9 readback");
    ctl(1'b1, 1'b1);
    chk(xlate_on == 1, "R2 xlate on", 32'(xlate_on), 32'd1);
    // R6 refused while translating
    int_we = 1; int_val = 1;
    tick();
    int_we = 0;
    chk(int_flag == 0, "R6 refused", 32'(int_flag), 32'd0);
    for (int v = 0; v < 9; v++)
      lookup(VT[v].acc, VT[v].va, VT[v].flt, VT[v].pa, "R3/R4/R5 vector");
    // R8 refill at head 0 then 1
    lookup(2'd3, 24'h040001, 1'b1, 24'h0, "R7 miss");
    refill(2'd3, 12'h777);
    rd_chk(3'd0, {12'h040, 12'h777, 2'd3}, "R8 head0");
    lookup(2'd3, 24'h040005, 1'b0, 24'h777005, "R8 refilled hit");
    lookup(2'd1, 24'h050000, 1'b1, 24'h0, "R7 miss2");
    refill(2'd1, 12'h555);
    rd_chk(3'd1, {12'h050, 12'h555, 2'd1}, "R8 head1");
    // R9 invalidate
    sw_write(3'd2, 26'd0);
    lookup(2'd3, 24'h030000, 1'b1, 24'h0, "R9 invalidated");
    // R10 toggle clears
    ctl(1'b0, 1'b1);
    ctl(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) rd_chk(3'(i), 26'd0, "R10 cleared");
    lookup(2'd1, 24'h010000, 1'b1, 24'h0, "R10 empty miss");
    refill(2'd1, 12'h999);
    rd_chk(3'd0, {12'h010, 12'h999, 2'd1}, "R10 head reset");
    // R6 accepted in kernel, R2 int flag stops translation
    ctl(1'b1, 1'b0);
    int_we = 1; int_val = 1;
    tick();
    int_we = 0;
    chk(int_flag == 1, "R6 accepted", 32'(int_flag), 32'd1);
    ctl(1'b1, 1'b1);
    chk(xlate_on == 0, "R2 int set", 32'(xlate_on), 32'd0);
    lookup(2'd2, 24'h040001, 1'b0, 24'h040001, "R2 int passthrough");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule